// File: doc/BRIEF.md
# Alternating-Level Pulse Sequencer

The sequencer plays a waveform made of alternating levels on a single envelope output. Each level lasts a whole number of base units: a shared unit length, counted in clock cycles, is multiplied by a small per-level factor taken from a table. The sequencer handles any protocol that can be written as a list of level durations, including ones that do not follow a header, symbol and trailer scheme. The envelope starts high and changes value at every new table entry. A carrier, if one is needed, is applied downstream.

A caller sets up the level count, the unit length and the table of factors, then pulses `start_i` while the block is idle. On that clock edge the block captures all of its inputs, so they may change freely during playback. It then walks the table and reports the end of the sequence with a one-cycle `done_o`.

The control path is a four-state machine:

- **IDLE**: waits for `start_i`. The IDLE→LAUNCH transition also captures the inputs.
- **LAUNCH**: one cycle in which the first entry with a non-zero length is found.
  - LAUNCH→PLAY is taken if such an entry exists.
  - LAUNCH→FINISH is taken if no entry exists.
- **PLAY**: drives the current level. When a level's time runs out:
  - PLAY→PLAY (reload) is taken if a later non-zero entry exists.
  - PLAY→FINISH is taken if no later non-zero entry exists.
- **FINISH**: asserts `done_o` for one cycle, then takes FINISH→IDLE.

Top module: `irseq_tx`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `env_o`, `busy_o` and `done_o` are all low.
- R2: `start_i` sampled high while idle captures the level count, the unit length and the table, and starts a sequence. In the next cycle `busy_o` is high and `env_o` is low (LAUNCH). The first level appears one cycle after that.
- R3: Table entry k is held in bits [4k+3:4k] of `table_i`, which is nibble k mod 8 of word k/8, with word n occupying bits [32n+31:32n]. Entry k keeps its level on `env_o` for exactly (entry k) × (unit length) clock cycles.
- R4: Entries are played in increasing index order. Entry k drives `env_o` high when k is even and low when k is odd, so the first entry is high and each later entry is the opposite of the one before it.
- R5: An entry whose factor is 0 takes no cycles, but it still counts toward the alternation of R4. A unit length of 0 makes every entry zero-length.
- R6: Only entries 0 to count−1 are played. A count of 0 plays nothing, and a count above 64 is treated as 64.
- R7: The cycle after the last played level, or the cycle after LAUNCH when nothing is played, has `done_o` high, `busy_o` high and `env_o` low. That cycle lasts exactly one cycle and the block is idle in the next one.
- R8: While busy, `start_i` and any change to the count, unit or table inputs have no effect on the sequence being played. This includes the cycle in which `done_o` is high.
- R9: Whenever `busy_o` is low, `env_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, acted on only while idle |
| level_cnt_i | input | 7 | Number of table entries to play (0 to 127, capped at 64) |
| unit_i | input | 12 | Base unit length in clock cycles |
| table_i | input | 256 | Eight 32-bit words holding 64 four-bit factors |
| env_o | output | 1 | Envelope output |
| busy_o | output | 1 | High from LAUNCH through FINISH |
| done_o | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The assertions assume that `start_i` is a synchronous signal that holds no unknown value once reset is released. The count, unit and table inputs need no such assumption, because they are captured only on the IDLE→LAUNCH edge and their values at other times cannot matter. The stimulus changes inputs only half a cycle away from the active edge. It keeps the unit length small, so that a full 64-entry table still finishes in a few thousand cycles. It deliberately changes the data inputs and pulses `start_i` during playback, including in the FINISH cycle, to show those values are ignored.

// File: rtl/irseq_pkg.sv
package irseq_pkg;

    // Sequencer control states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_PLAY   = 2'd2,
        ST_FINISH = 2'd3
    } irseq_state_e;

endpackage

// File: rtl/irseq_table.sv
// Captures the sequence description on start and marks which entries
// will actually occupy time on the output.
module irseq_table #(
    parameter int UNIT_W = 12,
    parameter int MULT_W = 4,
    parameter int LEVELS = 64,
    parameter int CNT_W  = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_i,
    input  logic [LEVELS*MULT_W-1:0]   table_i,
    input  logic [UNIT_W-1:0]          unit_i,
    input  logic [CNT_W-1:0]           count_i,
    output logic [LEVELS*MULT_W-1:0]   mults_o,
    output logic [UNIT_W-1:0]          unit_o,
    output logic [LEVELS-1:0]          live_o
);

    localparam logic [CNT_W-1:0] CNT_CAP = CNT_W'(LEVELS);

    logic [LEVELS*MULT_W-1:0] table_q;
    logic [UNIT_W-1:0]        unit_q;
    logic [CNT_W-1:0]         limit_q;
    logic [CNT_W-1:0]         limit_d;

    // Counts beyond the table size play the whole table
    always_comb begin
        limit_d = (count_i > CNT_CAP) ? CNT_CAP : count_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            table_q <= '0;
            unit_q  <= '0;
            limit_q <= '0;
        end else if (load_i) begin
            table_q <= table_i;
            unit_q  <= unit_i;
            limit_q <= limit_d;
        end
    end

    // An entry is live when it lies inside the count and has a non-zero length
    for (genvar g = 0; g < LEVELS; g++) begin : g_live
        assign live_o[g] = (table_q[g*MULT_W +: MULT_W] != '0)
                        && (CNT_W'(g) < limit_q)
                        && (unit_q != '0);
    end

    assign mults_o = table_q;
    assign unit_o  = unit_q;

endmodule

// File: rtl/irseq_seek.sv
// Finds the lowest live entry at or above a starting index.
module irseq_seek #(
    parameter int LEVELS = 64,
    parameter int IDX_W  = 6
) (
    input  logic [LEVELS-1:0] live_i,
    input  logic [IDX_W:0]    from_i,
    output logic              found_o,
    output logic [IDX_W-1:0]  idx_o
);

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int k = LEVELS - 1; k >= 0; k--) begin
            if (live_i[k] && (k >= int'(from_i))) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(k);
            end
        end
    end

endmodule

// File: rtl/irseq_timer.sv
// Two cascaded down-counters: unit cycles within each multiple, and
// multiples within the level.
module irseq_timer #(
    parameter int UNIT_W = 12,
    parameter int MULT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [UNIT_W-1:0] unit_i,
    input  logic [MULT_W-1:0] mult_i,
    input  logic              run_i,
    output logic              last_o
);

    logic [UNIT_W-1:0] unit_cnt_q;
    logic [MULT_W-1:0] mult_cnt_q;
    logic              unit_wrap;
    logic              mult_last;

    assign unit_wrap = (unit_cnt_q == UNIT_W'(1));
    assign mult_last = (mult_cnt_q == MULT_W'(1));
    assign last_o    = run_i && unit_wrap && mult_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unit_cnt_q <= '0;
            mult_cnt_q <= '0;
        end else if (load_i) begin
            unit_cnt_q <= unit_i;
            mult_cnt_q <= mult_i;
        end else if (run_i) begin
            if (unit_wrap) begin
                if (!mult_last) begin
                    mult_cnt_q <= mult_cnt_q - MULT_W'(1);
                    unit_cnt_q <= unit_i;
                end
            end else begin
                unit_cnt_q <= unit_cnt_q - UNIT_W'(1);
            end
        end
    end

    // R3: a level being played was loaded with a non-zero length
    p_level_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (unit_cnt_q != '0) && (mult_cnt_q != '0));

endmodule

// File: rtl/irseq_tx.sv
// Alternating-level pulse sequencer, top level.
module irseq_tx
    import irseq_pkg::*;
#(
    parameter int UNIT_W    = 12,
    parameter int MULT_W    = 4,
    parameter int NUM_WORDS = 8,
    parameter int WORD_W    = 32,
    localparam int TABLE_W  = NUM_WORDS * WORD_W,
    localparam int LEVELS   = TABLE_W / MULT_W,
    localparam int IDX_W    = $clog2(LEVELS),
    localparam int CNT_W    = $clog2(LEVELS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [CNT_W-1:0]   level_cnt_i,
    input  logic [UNIT_W-1:0]  unit_i,
    input  logic [TABLE_W-1:0] table_i,
    output logic               env_o,
    output logic               busy_o,
    output logic               done_o
);

    irseq_state_e state_q, state_d;

    logic [IDX_W-1:0]         idx_q;
    logic [LEVELS*MULT_W-1:0] mults;
    logic [UNIT_W-1:0]        unit_lat;
    logic [LEVELS-1:0]        live;
    logic [IDX_W:0]           seek_from;
    logic                     seek_found;
    logic [IDX_W-1:0]         seek_idx;
    logic                     table_load;
    logic                     timer_load;
    logic                     timer_run;
    logic                     level_end;
    logic [MULT_W-1:0]        next_mult;

    irseq_table #(
        .UNIT_W (UNIT_W),
        .MULT_W (MULT_W),
        .LEVELS (LEVELS),
        .CNT_W  (CNT_W)
    ) table_i0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (table_load),
        .table_i (table_i),
        .unit_i  (unit_i),
        .count_i (level_cnt_i),
        .mults_o (mults),
        .unit_o  (unit_lat),
        .live_o  (live)
    );

    irseq_seek #(
        .LEVELS (LEVELS),
        .IDX_W  (IDX_W)
    ) seek_i0 (
        .live_i  (live),
        .from_i  (seek_from),
        .found_o (seek_found),
        .idx_o   (seek_idx)
    );

    irseq_timer #(
        .UNIT_W (UNIT_W),
        .MULT_W (MULT_W)
    ) timer_i0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (timer_load),
        .unit_i (unit_lat),
        .mult_i (next_mult),
        .run_i  (timer_run),
        .last_o (level_end)
    );

    // Search begins at entry 0 on launch, after the current entry during play
    assign seek_from  = (state_q == ST_PLAY)
                      ? ({1'b0, idx_q} + (IDX_W+1)'(1))
                      : '0;
    assign next_mult  = mults[seek_idx*MULT_W +: MULT_W];
    assign table_load = (state_q == ST_IDLE) && start_i;
    assign timer_run  = (state_q == ST_PLAY);
    assign timer_load = seek_found
                     && ((state_q == ST_LAUNCH) || ((state_q == ST_PLAY) && level_end));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (timer_load) begin
                idx_q <= seek_idx;
            end
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_LAUNCH;
            ST_LAUNCH: state_d = seek_found ? ST_PLAY : ST_FINISH;
            ST_PLAY:   if (level_end) state_d = seek_found ? ST_PLAY : ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs; level value follows entry parity
    always_comb begin
        env_o  = 1'b0;
        busy_o = 1'b1;
        done_o = 1'b0;
        unique case (state_q)
            ST_IDLE:   busy_o = 1'b0;
            ST_LAUNCH: ;
            ST_PLAY:   env_o  = ~idx_q[0];
            ST_FINISH: done_o = 1'b1;
            default:   busy_o = 1'b0;
        endcase
    end

    // R7: end pulse lasts one cycle
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && !busy_o);

    // R7: end cycle is busy with the envelope low
    p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o && !env_o);

    // R9: no envelope while idle
    p_env_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !env_o);

    // R2: an accepted start leads to a quiet busy cycle
    p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o && !env_o && !done_o);

    // R8: a running sequence stays busy until its end pulse
    p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

    // R4: consecutive played entries advance in index order
    p_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_run && timer_load) |-> (seek_idx > idx_q));

endmodule

// File: tb/irseq_tx_tb_top.sv
module irseq_tx_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [6:0]   level_cnt_i = '0;
    logic [11:0]  unit_i = '0;
    logic [255:0] table_i = '0;
    logic         env_o, busy_o, done_o;

    int    vectors = 0;
    int    errs = 0;
    int    cyc = 0;
    string tag = "R1";
    bit    [2:0] q[$];   // {env, busy, done} expected per cycle

    always #2.5 clk = ~clk;

    irseq_tx dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .level_cnt_i (level_cnt_i),
        .unit_i      (unit_i),
        .table_i     (table_i),
        .env_o       (env_o),
        .busy_o      (busy_o),
        .done_o      (done_o)
    );

    // Behavioural model: expand a request into a per-cycle expectation list
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
        end else if (q.size() > 0) begin
            void'(q.pop_front());            // R8: start ignored while busy
        end else if (start_i) begin
            int lim;
            lim = (level_cnt_i > 7'd64) ? 64 : int'(level_cnt_i);  // R6
            q.push_back(3'b010);             // R2 launch cycle
            for (int k = 0; k < lim; k++) begin
                int m;
                m = int'(table_i[4*k +: 4]);                         // R3
                for (int c = 0; c < m * int'(unit_i); c++)           // R5
                    q.push_back({~k[0], 2'b10});                     // R4
            end
            q.push_back(3'b011);             // R7 end cycle
        end
    end

    // Compare every cycle away from the active edge (R9 covered by idle cycles)
    always @(negedge clk) begin
        bit [2:0] exp;
        exp = (q.size() > 0) ? q[0] : 3'b000;
        vectors++;
        if ({env_o, busy_o, done_o} !== exp) begin
            errs++;
            $display("FAIL %s cycle %0d: env/busy/done actual %b%b%b expected %b",
                     tag, cyc, env_o, busy_o, done_o, exp);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errs++;
            $display("FAIL R2 watchdog expired at cycle %0d", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
            $finish;
        end
    end

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic wait_idle();
        while (q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic run(input string t, input int cnt, input int unit);
        tag = t;
        level_cnt_i = 7'(cnt);
        unit_i = 12'(unit);
        pulse_start();
        wait_idle();
    endtask

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R3 R4: basic sequence
        table_i = '0;
        table_i[15:0] = 16'h3121;
        run("R3", 4, 3);

        // R3: entries spanning word boundaries
        table_i = '0;
        for (int k = 6; k < 11; k++) table_i[4*k +: 4] = 4'(k - 4);
        table_i[4*10 +: 4] = 4'hF;
        run("R3", 11, 2);

        // R5: zero entries at the start, middle and end
        table_i = '0;
        table_i[4*1 +: 4] = 4'd2;
        table_i[4*4 +: 4] = 4'd1;
        table_i[4*5 +: 4] = 4'd3;
        run("R5", 7, 2);

        // R5: zero unit length
        table_i = {8{32'h5A5A_5A5A}};
        run("R5", 20, 0);

        // R6: count of zero, full table, capped count
        run("R6", 0, 3);
        table_i = {8{32'h1234_5671}};
        run("R6", 64, 1);
        run("R6", 100, 1);
        table_i[255:252] = 4'd0;
        run("R6", 127, 2);

        // R8: inputs and start changed during play
        tag = "R8";
        table_i = {8{32'h2222_2222}};
        level_cnt_i = 7'd6;
        unit_i = 12'd3;
        pulse_start();
        repeat (5) @(negedge clk);
        table_i = {8{32'hFFFF_FFFF}};
        unit_i = 12'd9;
        level_cnt_i = 7'd64;
        pulse_start();
        // start raised during the end cycle
        unit_i = 12'd1;
        level_cnt_i = 7'd2;
        table_i = {8{32'h0000_0011}};
        while (q.size() != 1) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        repeat (2) @(negedge clk);
        // R2: immediate restart from idle
        tag = "R2";
        pulse_start();
        pulse_start();
        wait_idle();

        // R4 R7: random tables
        for (int t = 0; t < 6; t++) begin
            for (int w = 0; w < 8; w++) table_i[32*w +: 32] = $urandom();
            run("R7", $urandom_range(64, 1), $urandom_range(4, 1));
        end
        tag = "R9";
        repeat (4) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

endmodule